// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is the DMA master that sits inside a memory-card data path. It moves words between system memory and the card-side word stream. Each pass covers one buffer, given by a byte address and a byte length. In the simple mode, software writes one buffer address and one length and starts the engine. In the chained mode, the engine reads the next buffer from a list of three-word descriptors in memory each time a buffer finishes.

Every descriptor holds three words, and the engine reads them in this order: a link word, a buffer address and a buffer length. The low bits of the link word give the byte offset of the next descriptor, measured from a list-base register. The link word also carries flags:
- A "more" flag says that another descriptor follows. A buffer whose link word has this flag clear is the last one.
- A "take size" flag says whether the length is reloaded from the next descriptor or the previous length is kept.
- An acknowledge flag must be set by software on every descriptor. The engine stores it but never checks it.

After the final buffer the engine gives a one-cycle completion pulse. If a buffer address that is not word aligned is loaded, the engine does not start that buffer and raises a sticky error flag instead.

Top module: `lldma_engine`

## Requirements
- R1: After reset the engine is idle. It makes no memory request, `done` and `err` are low, and every register reads as zero: control at index 0, list base at 1, link at 2, buffer base at 3, buffer size at 4, status at 5 (bit 0 busy, bit 1 error).
- R2: Writing control with the run bit (bit 0) set while idle transfers ceil(size/4) words, starting at the base register and moving upward by 4 bytes. If the chain bit (bit 1) is clear, the engine stops after that buffer even when the link word's more flag is set.
- R3: Control bit 2 selects the direction. A value of 1 reads memory and sends each word on the outgoing stream, in address order. A value of 0 takes words from the incoming stream and writes them to memory. No word is written past the end of a buffer.
- R4: At the end of a buffer, when the chain bit is set and the link word's more flag (bit 18) is set, the engine reads three words at list base + link[15:0] + 0/4/8, in that order: link, base, size. The next buffer then starts from the new base.
- R5: The size is reloaded from the fetched descriptor only if the finished buffer's link word has the take-size flag (bit 17) set. Otherwise the previous size is used again.
- R6: When the last buffer ends, `done` pulses high for exactly one cycle and the engine goes idle. This happens once per run.
- R7: If a base with either of its low two bits set is loaded, at start or from a descriptor, no word is moved from it. `err` is then set and stays set, the engine goes idle and no `done` pulse follows. The next control write clears `err`.
- R8: Writing control with the run bit clear stops the engine at once. From the next cycle on there is no memory request, no further stream word and no `done` pulse.
- R9: While the engine is busy, writes to the list, link, base and size registers are ignored. A control write with the run bit set is also ignored.
- R10: A buffer of size zero moves no words. The engine then goes on to the next descriptor, or finishes.
- R11: Every memory address is word aligned. The address and the request stay unchanged until the memory acknowledges the request.
- R12: After a chained run, the link, base and size registers hold the values taken from the last descriptor that was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the register at `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data is valid with it |
| mem_rdata | input | 32 | Memory read data |
| sin_valid | input | 1 | Incoming card word valid (held until accepted) |
| sin_data | input | 32 | Incoming card word |
| sin_ready | output | 1 | Incoming word accepted |
| sout_valid | output | 1 | Outgoing card word valid |
| sout_data | output | 32 | Outgoing card word |
| sout_ready | input | 1 | Sink can take a word (held while a request is open) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky misaligned-base error |

## Verification
Three situations are hard to reach from the ports:
- A descriptor fetch that loads a misaligned base partway through a chain. The bench reaches it by placing an unaligned address in the second descriptor in memory, so the first buffer completes normally before the fault.
- A stop request that arrives while a memory access is still open. The bench reaches it by running a long read against a memory model that stalls every other cycle, then writing zero to control in the middle of the run.
- Register writes while busy, which must have no effect. The bench holds the outgoing stream not-ready, so the engine stays busy with no memory traffic while those writes and readbacks are made.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FETCH = 2'd2
  } lldma_state_e;

  // Register word indices
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_LIST = 3'd1;
  localparam logic [2:0] REG_LINK = 3'd2;
  localparam logic [2:0] REG_BASE = 3'd3;
  localparam logic [2:0] REG_SIZE = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  // Control bits
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_CHAIN = 1;
  localparam int CTRL_DIRRD = 2;

  // Link word flags
  localparam int FLAG_ACK  = 16;
  localparam int FLAG_SIZE = 17;
  localparam int FLAG_MORE = 18;

  function automatic logic [32:0] words_of(input logic [31:0] bytes);
    return ({1'b0, bytes} + 33'd3) >> 2;
  endfunction

  function automatic logic word_aligned(input logic [31:0] addr);
    return addr[1:0] == 2'b00;
  endfunction

  function automatic logic [31:0] desc_word_addr(input logic [31:0] list,
                                                 input logic [31:0] ofs,
                                                 input logic [1:0]  idx);
    return list + ofs + {28'd0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/lldma_beat_ctr.sv
module lldma_beat_ctr #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_addr,
  input  logic [CNT_W-1:0] load_words,
  input  logic             step,
  output logic [31:0]      ptr,
  output logic             empty
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      left_q <= '0;
    end else if (load) begin
      ptr    <= load_addr;
      left_q <= load_words;
    end else if (step) begin
      ptr    <= ptr + 32'd4;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign empty = left_q == '0;
endmodule

// File: rtl/lldma_port_mux.sv
module lldma_port_mux (
  input  logic        xfer_act,
  input  logic        fetch_act,
  input  logic        dir_rd,
  input  logic [31:0] ptr,
  input  logic [31:0] fetch_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        sin_valid,
  input  logic [31:0] sin_data,
  input  logic        sout_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        sin_ready,
  output logic        sout_valid,
  output logic [31:0] sout_data,
  output logic        xfer_beat,
  output logic        fetch_beat
);
  logic xfer_req;

  assign xfer_req   = xfer_act & (dir_rd ? sout_ready : sin_valid);
  assign mem_req    = fetch_act | xfer_req;
  assign mem_we     = xfer_act & ~dir_rd;
  assign mem_addr   = fetch_act ? fetch_addr : ptr;
  assign mem_wdata  = sin_data;
  assign xfer_beat  = xfer_req & mem_ack;
  assign fetch_beat = fetch_act & mem_ack;
  assign sin_ready  = xfer_beat & ~dir_rd;
  assign sout_valid = xfer_beat & dir_rd;
  assign sout_data  = mem_rdata;
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int CNT_W = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        sin_valid,
  input  logic [31:0] sin_data,
  output logic        sin_ready,
  output logic        sout_valid,
  output logic [31:0] sout_data,
  input  logic        sout_ready,
  output logic        done,
  output logic        err
);
  localparam int FIDX_W = 2;
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(2);

  lldma_state_e      state;
  logic [2:0]        ctrl_q;
  logic [31:0]       list_q, link_q, base_q, size_q, nlink_q, nbase_q;
  logic [FIDX_W-1:0] fidx_q;
  logic              err_q, done_q;

  // Named internal events
  logic              busy, xfer_act, fetch_act, buf_end, chain_go;
  logic              xfer_beat, fetch_beat, fetch_last, fetch_ok;
  logic              wr_ctrl, wr_cfg, start, load, empty;
  logic [31:0]       ptr, fetch_addr_w, load_addr, next_size;
  logic [CNT_W-1:0]  load_words;

  assign busy       = state != ST_IDLE;
  assign wr_ctrl    = reg_wr && reg_addr == REG_CTRL;
  assign wr_cfg     = reg_wr && !busy;
  assign start      = wr_ctrl && reg_wdata[CTRL_RUN] && !busy && word_aligned(base_q);
  assign xfer_act   = state == ST_XFER && !empty;
  assign buf_end    = state == ST_XFER && empty;
  assign fetch_act  = state == ST_FETCH;
  assign chain_go   = ctrl_q[CTRL_CHAIN] && link_q[FLAG_MORE];
  assign fetch_last = fetch_beat && fidx_q == FIDX_LAST;
  assign fetch_ok   = fetch_last && word_aligned(nbase_q);
  assign load       = start || fetch_ok;
  assign next_size  = link_q[FLAG_SIZE] ? mem_rdata : size_q;
  assign load_addr  = start ? base_q : nbase_q;
  assign load_words = CNT_W'(words_of(start ? size_q : next_size));
  assign fetch_addr_w = desc_word_addr(list_q, 32'(link_q[OFS_W-1:0]), fidx_q);

  lldma_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .load_words(load_words), .step(xfer_beat), .ptr(ptr), .empty(empty)
  );

  lldma_port_mux u_mux (
    .xfer_act(xfer_act), .fetch_act(fetch_act), .dir_rd(ctrl_q[CTRL_DIRRD]),
    .ptr(ptr), .fetch_addr(fetch_addr_w), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sin_valid(sin_valid), .sin_data(sin_data), .sout_ready(sout_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sin_ready(sin_ready), .sout_valid(sout_valid), .sout_data(sout_data),
    .xfer_beat(xfer_beat), .fetch_beat(fetch_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ctrl_q  <= '0;
      list_q  <= '0;
      link_q  <= '0;
      base_q  <= '0;
      size_q  <= '0;
      nlink_q <= '0;
      nbase_q <= '0;
      fidx_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_cfg) begin
        unique case (reg_addr)
          REG_LIST: list_q <= reg_wdata;
          REG_LINK: link_q <= reg_wdata;
          REG_BASE: base_q <= reg_wdata;
          REG_SIZE: size_q <= reg_wdata;
          default: ;
        endcase
      end
      unique case (state)
        ST_XFER: if (buf_end) begin
          if (chain_go) begin
            state  <= ST_FETCH;
            fidx_q <= '0;
          end else begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_FETCH: if (fetch_beat) begin
          fidx_q <= fidx_q + FIDX_W'(1);
          if (fidx_q == FIDX_W'(0)) nlink_q <= mem_rdata;
          if (fidx_q == FIDX_W'(1)) nbase_q <= mem_rdata;
          if (fetch_last) begin
            link_q <= nlink_q;
            base_q <= nbase_q;
            size_q <= next_size;
            if (fetch_ok) state <= ST_XFER;
            else begin
              state <= ST_IDLE;
              err_q <= 1'b1;
            end
          end
        end
        default: ;
      endcase
      if (wr_ctrl && (!busy || !reg_wdata[CTRL_RUN])) begin
        ctrl_q <= reg_wdata[2:0];
        err_q  <= 1'b0;
        if (!reg_wdata[CTRL_RUN]) begin
          state  <= ST_IDLE;
          done_q <= 1'b0;
        end else if (start) state <= ST_XFER;
        else err_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_CTRL: reg_rdata = {29'd0, ctrl_q};
      REG_LIST: reg_rdata = list_q;
      REG_LINK: reg_rdata = link_q;
      REG_BASE: reg_rdata = base_q;
      REG_SIZE: reg_rdata = size_q;
      REG_STAT: reg_rdata = {30'd0, err_q, busy};
      default:  reg_rdata = '0;
    endcase
  end

  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/lldma_engine_chk.sv
module lldma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        done,
  input logic        err
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_stop_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |=> !mem_req);

  assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr)));

  assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !done);
endmodule

bind lldma_engine lldma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .done(done), .err(err)
);

// File: tb/lldma_engine_tb.sv
module lldma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        sin_valid, sin_ready, sout_valid;
  logic [31:0] sin_data, sout_data;
  logic        sout_ready = 1'b1;
  logic        done, err;

  always #5 clk = ~clk;

  lldma_engine u_dut (.*);

  // Memory and stream models
  logic [31:0] img  [0:255];   // preset image, written by the stimulus only
  logic [31:0] wmem [0:255];   // words written by the engine
  int          wgen [0:255];
  int          cur_gen = 1;
  logic        ack_r = 1'b0, tick = 1'b0, stall = 1'b0, src_en = 1'b0;
  logic [31:0] rdata_r = '0;
  int          src_i = 0, snk_n = 0, done_cnt = 0, bad_addr = 0;
  logic [31:0] snk [0:1023];

  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;
  assign sin_valid = src_en;
  assign sin_data  = 32'hA500_0000 + 32'(src_i);

  always @(posedge clk) begin
    tick <= ~tick;
    if (mem_req && mem_we && ack_r) begin
      wmem[mem_addr[9:2]] = mem_wdata;
      wgen[mem_addr[9:2]] = cur_gen;
    end
    rdata_r <= img[mem_addr[9:2]];
    ack_r   <= mem_req && !ack_r && !(stall && tick);
    if (sin_valid && sin_ready) src_i <= src_i + 1;
    if (sout_valid && sout_ready) begin
      snk[snk_n[9:0]] <= sout_data;
      snk_n <= snk_n + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
    if (mem_req && mem_addr[1:0] != 2'b00) bad_addr <= bad_addr + 1;
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int k = 0; k < 3000; k++) begin
      rreg(3'd5, st);
      if (!st[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_img();
    for (int i = 0; i < 256; i++) img[i] = pat(i);
  endtask

  task automatic put_desc(input int byte_addr, input logic [31:0] lnk,
                          input logic [31:0] b, input logic [31:0] s);
    img[byte_addr/4]     = lnk;
    img[byte_addr/4 + 1] = b;
    img[byte_addr/4 + 2] = s;
  endtask

  task automatic load_regs(input logic [31:0] l, input logic [31:0] lk,
                           input logic [31:0] b, input logic [31:0] s);
    wreg(3'd1, l); wreg(3'd2, lk); wreg(3'd3, b); wreg(3'd4, s);
  endtask

  localparam logic [31:0] F_ACK  = 32'h0001_0000;
  localparam logic [31:0] F_SIZE = 32'h0002_0000;
  localparam logic [31:0] F_MORE = 32'h0004_0000;
  localparam int LIST = 32'h300;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n0, d0, s0, nw, c;
    for (int i = 0; i < 256; i++) begin wmem[i] = '0; wgen[i] = 0; end
    fill_img();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(!mem_req && !done && !err, "R1 outputs after reset", {29'd0, mem_req, done, err}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), rd);
      chk(rd == 32'd0, "R1 register reset value", rd, 32'd0);
    end

    // R2 / R3 / R10: single-buffer reads, sizes 0..9, stall alternating
    for (int s = 0; s <= 9; s++) begin
      stall = s[0];
      n0 = snk_n; d0 = done_cnt;
      load_regs(32'd0, F_MORE | F_ACK | 32'd12, 32'h100, 32'(s));
      wreg(3'd0, 32'h5);           // run, read direction, chain off
      wait_idle();
      nw = (s + 3) / 4;
      chk(snk_n - n0 == nw, "R2 word count single read", 32'(snk_n - n0), 32'(nw));
      for (int k = 0; k < nw; k++)
        chk(snk[n0 + k] == pat(64 + k), "R3 read data order", snk[n0 + k], pat(64 + k));
      chk(done_cnt - d0 == 1, (s == 0) ? "R10 zero-size done" : "R6 single done pulse",
          32'(done_cnt - d0), 32'd1);
    end
    stall = 1'b0;

    // R3: single-buffer writes from the incoming stream
    for (int s = 1; s <= 10; s++) begin
      cur_gen++;
      stall = s[1];
      s0 = src_i;
      src_en = 1'b1;
      load_regs(32'd0, 32'd0, 32'h200, 32'(s));
      wreg(3'd0, 32'h1);
      wait_idle();
      src_en = 1'b0;
      nw = (s + 3) / 4;
      for (int k = 0; k < nw; k++)
        chk(wgen[128 + k] == cur_gen && wmem[128 + k] == 32'hA500_0000 + 32'(s0 + k),
            "R3 written word", wmem[128 + k], 32'hA500_0000 + 32'(s0 + k));
      chk(wgen[128 + nw] != cur_gen, "R3 no write past buffer", 32'(wgen[128 + nw]), 32'd0);
    end
    stall = 1'b0;

    // R4 / R6 / R12: three-descriptor chain read, with and without stalls
    for (int v = 0; v < 2; v++) begin
      stall = v[0];
      fill_img();
      put_desc(LIST,      F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
      put_desc(LIST + 12, F_ACK | F_SIZE | F_MORE | 32'd24, 32'h80, 32'd12);
      put_desc(LIST + 24, F_ACK | F_SIZE | 32'd36,          32'hC0, 32'd6);
      n0 = snk_n; d0 = done_cnt;
      load_regs(LIST, F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
      wreg(3'd0, 32'h7);
      wait_idle();
      chk(snk_n - n0 == 7, "R4 chained word count", 32'(snk_n - n0), 32'd7);
      for (int k = 0; k < 2; k++) chk(snk[n0 + k] == pat(16 + k), "R4 buffer0 data", snk[n0 + k], pat(16 + k));
      for (int k = 0; k < 3; k++) chk(snk[n0 + 2 + k] == pat(32 + k), "R4 buffer1 data", snk[n0 + 2 + k], pat(32 + k));
      for (int k = 0; k < 2; k++) chk(snk[n0 + 5 + k] == pat(48 + k), "R4 buffer2 data", snk[n0 + 5 + k], pat(48 + k));
      chk(done_cnt - d0 == 1, "R6 chain done once", 32'(done_cnt - d0), 32'd1);
      rreg(3'd2, rd); chk(rd == (F_ACK | F_SIZE | 32'd36), "R12 link readback", rd, F_ACK | F_SIZE | 32'd36);
      rreg(3'd3, rd); chk(rd == 32'hC0, "R12 base readback", rd, 32'hC0);
      rreg(3'd4, rd); chk(rd == 32'd6, "R12 size readback", rd, 32'd6);
    end
    stall = 1'b0;

    // R5: take-size flag clear on descriptor 0, so buffer1 reuses 8 bytes
    fill_img();
    put_desc(LIST + 12, F_ACK | F_SIZE | F_MORE | 32'd24, 32'h80, 32'd40);
    put_desc(LIST + 24, F_ACK | 32'd36, 32'hC0, 32'd6);
    n0 = snk_n;
    load_regs(LIST, F_ACK | F_MORE | 32'd12, 32'h40, 32'd8);
    wreg(3'd0, 32'h7);
    wait_idle();
    chk(snk_n - n0 == 6, "R5 size kept then reloaded", 32'(snk_n - n0), 32'd6);
    chk(snk[n0 + 3] == pat(33), "R5 buffer1 second word", snk[n0 + 3], pat(33));
    rreg(3'd4, rd); chk(rd == 32'd6, "R5 size register", rd, 32'd6);

    // R2: chain bit clear, more flag set, stops after first buffer
    n0 = snk_n; d0 = done_cnt;
    load_regs(LIST, F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
    wreg(3'd0, 32'h5);
    wait_idle();
    chk(snk_n - n0 == 2, "R2 chain disabled stops", 32'(snk_n - n0), 32'd2);
    rreg(3'd2, rd); chk(rd == (F_ACK | F_SIZE | F_MORE | 32'd12), "R2 link not reloaded", rd, F_ACK | F_SIZE | F_MORE | 32'd12);

    // R10: zero-size middle descriptor in a chain
    fill_img();
    put_desc(LIST + 12, F_ACK | F_SIZE | F_MORE | 32'd24, 32'h80, 32'd0);
    put_desc(LIST + 24, F_ACK | F_SIZE | 32'd36, 32'hC0, 32'd5);
    n0 = snk_n; d0 = done_cnt;
    load_regs(LIST, F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
    wreg(3'd0, 32'h7);
    wait_idle();
    chk(snk_n - n0 == 4, "R10 zero-size buffer skipped", 32'(snk_n - n0), 32'd4);
    chk(snk[n0 + 2] == pat(48), "R10 next buffer data", snk[n0 + 2], pat(48));
    chk(done_cnt - d0 == 1, "R10 done once", 32'(done_cnt - d0), 32'd1);

    // R3 / R4: chained write with stalls
    cur_gen++;
    stall = 1'b1;
    fill_img();
    put_desc(LIST + 12, F_ACK | F_SIZE | F_MORE | 32'd24, 32'h80, 32'd12);
    put_desc(LIST + 24, F_ACK | F_SIZE | 32'd36, 32'hC0, 32'd6);
    s0 = src_i;
    src_en = 1'b1;
    load_regs(LIST, F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
    wreg(3'd0, 32'h3);
    wait_idle();
    src_en = 1'b0;
    stall = 1'b0;
    chk(src_i - s0 == 7, "R4 chained write words", 32'(src_i - s0), 32'd7);
    chk(wmem[17] == 32'hA500_0000 + 32'(s0 + 1), "R3 chained write buf0", wmem[17], 32'hA500_0000 + 32'(s0 + 1));
    chk(wmem[34] == 32'hA500_0000 + 32'(s0 + 4), "R3 chained write buf1", wmem[34], 32'hA500_0000 + 32'(s0 + 4));
    chk(wmem[49] == 32'hA500_0000 + 32'(s0 + 6), "R3 chained write buf2", wmem[49], 32'hA500_0000 + 32'(s0 + 6));
    chk(wgen[50] != cur_gen, "R3 chained no overrun", 32'(wgen[50]), 32'd0);

    // R7: misaligned start base
    n0 = snk_n; d0 = done_cnt;
    load_regs(32'd0, 32'd0, 32'h102, 32'd8);
    wreg(3'd0, 32'h5);
    rreg(3'd5, rd);
    chk(rd == 32'h2 && err, "R7 misaligned start err", rd, 32'h2);
    repeat (10) @(negedge clk);
    chk(snk_n == n0 && done_cnt == d0, "R7 nothing moved", 32'(snk_n - n0), 32'd0);
    wreg(3'd0, 32'h0);
    chk(!err, "R7 err cleared by control write", {31'd0, err}, 32'd0);

    // R7: misaligned base from second descriptor
    fill_img();
    put_desc(LIST + 12, F_ACK | F_SIZE | 32'd24, 32'h82, 32'd8);
    n0 = snk_n; d0 = done_cnt;
    load_regs(LIST, F_ACK | F_SIZE | F_MORE | 32'd12, 32'h40, 32'd8);
    wreg(3'd0, 32'h7);
    wait_idle();
    chk(snk_n - n0 == 2, "R7 only first buffer moved", 32'(snk_n - n0), 32'd2);
    chk(err && done_cnt == d0, "R7 fetch err and no done", {30'd0, err, 1'b0} | 32'(done_cnt - d0), 32'h2);

    // R8: stop in the middle of a long stalled read
    stall = 1'b1;
    n0 = snk_n; d0 = done_cnt;
    load_regs(32'd0, 32'd0, 32'h0, 32'd256);
    wreg(3'd0, 32'h5);
    repeat (12) @(negedge clk);
    wreg(3'd0, 32'h0);
    c = snk_n;
    repeat (30) @(negedge clk);
    chk(snk_n == c, "R8 no words after stop", 32'(snk_n), 32'(c));
    chk(c - n0 > 0 && c - n0 < 64, "R8 stopped partway", 32'(c - n0), 32'd64);
    chk(done_cnt == d0 && !mem_req, "R8 no done no request", 32'(done_cnt - d0), 32'd0);
    stall = 1'b0;

    // R9: writes while busy are ignored
    sout_ready = 1'b0;
    n0 = snk_n;
    load_regs(LIST, 32'd0, 32'h40, 32'd16);
    wreg(3'd0, 32'h5);
    load_regs(32'h10, 32'h20, 32'h200, 32'd4);
    wreg(3'd0, 32'h1);
    rreg(3'd5, rd); chk(rd[0] == 1'b1, "R9 still busy", rd, 32'h1);
    rreg(3'd3, rd); chk(rd == 32'h40, "R9 base unchanged", rd, 32'h40);
    rreg(3'd4, rd); chk(rd == 32'd16, "R9 size unchanged", rd, 32'd16);
    rreg(3'd1, rd); chk(rd == LIST, "R9 list unchanged", rd, LIST);
    rreg(3'd0, rd); chk(rd == 32'h5, "R9 control unchanged", rd, 32'h5);
    sout_ready = 1'b1;
    wait_idle();
    chk(snk_n - n0 == 4, "R9 original size used", 32'(snk_n - n0), 32'd4);
    chk(snk[n0] == pat(16), "R9 original base used", snk[n0], pat(16));

    // R11: every request address word aligned
    chk(bad_addr == 0, "R11 aligned addresses", 32'(bad_addr), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule